// File: doc/BRIEF.md
# Immediate Extension Prefix Unit

This block sits in the source-operand path of a 32-bit core. The core's instructions carry a source immediate of only 9 bits. A prefix operation parks a 23-bit value in a hidden register. Each hardware task has its own hidden register. The next immediate-using instruction issued by the same task merges the parked value into its 9-bit field to form a full 32-bit operand. That register then returns to zero.

The prefix has two forms:
- **High form:** places the payload at bits 31:9.
- **Low form:** places the payload at bits 22:0.

The merge is a bitwise OR, so the operand path holds no adder. A register holding zero leaves an unprefixed immediate unchanged, so the merge can be applied to every immediate.

The interface is a plain issue-slot strobe, one instruction per cycle. There is no valid/ready handshake and no back-pressure. Every strobe is taken in the cycle it is raised. The operand output is combinational from the inputs and the stored registers.

Top module: `imx_prefix_unit`

## Requirements
- R1: Reset sets all four hidden registers to zero. After reset, an immediate on any task yields its 9-bit field zero-extended.
- R2: A high-form prefix (`pfx_high`=1) with payload P makes the next immediate of that task yield `{P, field}`.
- R3: A low-form prefix (`pfx_high`=0) with payload P makes the next immediate of that task yield `{9'b0, P} | field`. This is a bitwise OR, not a sum.
- R4: An immediate consumes the pending value and clears it. `imm_valid` is raised for every issued immediate instruction, including one whose condition fails. The following immediate of that task therefore yields its field alone.
- R5: Tasks are independent. A prefix or an immediate on one task neither reads nor alters the register of another task.
- R6: A cycle with `imm_valid` low leaves every pending value untouched. Such a cycle can be a register-source instruction or an idle slot.
- R7: A second prefix on a task before consumption overwrites the pending value.
- R8: When a prefix and an immediate of the same task arrive in one cycle, the immediate uses the value held before that cycle. The new prefix is the one kept.
- R9: `operand` is zero whenever `imm_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| task_id | input | 2 | Hardware task issuing this cycle |
| pfx_valid | input | 1 | Prefix operation issued this cycle |
| pfx_high | input | 1 | Prefix form: 1 = high (bits 31:9), 0 = low (bits 22:0) |
| pfx_payload | input | 23 | Prefix payload |
| imm_valid | input | 1 | Immediate-using instruction issued this cycle |
| imm_field | input | 9 | Native 9-bit immediate field |
| operand | output | 32 | Widened source operand |

## Verification
The low-form test pairs a payload and field whose overlapping bits would carry under addition. An adder in place of the OR would return a different value there. Back-to-back immediates on one task catch a register that fails to clear: the second result would still carry the old prefix. Interleaving prefixes across tasks, and leaving idle cycles between a prefix and its use, exposes a shared or wrongly indexed register and any leak on idle cycles. A same-cycle prefix-plus-immediate case, a double prefix, and a reset with a value still pending catch a wrong update priority and a reset that misses a register.

// File: rtl/imx_pkg.sv
package imx_pkg;
  localparam int IMM_W  = 9;
  localparam int PFX_W  = 23;
  localparam int WORD_W = 32;
  localparam int HI_SHIFT = WORD_W - PFX_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PFX_W-1:0]  pfx_t;
  typedef logic [IMM_W-1:0]  imm_t;

  function automatic word_t place_prefix(input logic high, input pfx_t payload);
    word_t w;
    if (high) w = {payload, {HI_SHIFT{1'b0}}};
    else      w = {{(WORD_W-PFX_W){1'b0}}, payload};
    return w;
  endfunction
endpackage

// File: rtl/imx_slot.sv
module imx_slot
  import imx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  load_high,
  input  pfx_t  load_payload,
  input  logic  consume,
  output word_t held
);
  word_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       held_q <= '0;
    else if (load)    held_q <= place_prefix(load_high, load_payload);
    else if (consume) held_q <= '0;
  end

  assign held = held_q;

  p_clear_after_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !load) |=> (held == '0));
  p_high_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_high) |=> (held[HI_SHIFT-1:0] == '0 && held[WORD_W-1:HI_SHIFT] == $past(load_payload)));
  p_low_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_high) |=> (held[WORD_W-1:PFX_W] == '0 && held[PFX_W-1:0] == $past(load_payload)));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !consume) |=> $stable(held));
endmodule

// File: rtl/imx_merge.sv
module imx_merge
  import imx_pkg::*;
#(
  parameter int TASK_N = 4,
  localparam int TID_W = (TASK_N > 1) ? $clog2(TASK_N) : 1
) (
  input  word_t            held [TASK_N],
  input  logic [TID_W-1:0] task_id,
  input  logic             imm_valid,
  input  imm_t             imm_field,
  output word_t            operand
);
  word_t sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < TASK_N; i++)
      if (task_id == TID_W'(i)) sel = held[i];
  end

  assign operand = imm_valid ? (sel | {{(WORD_W-IMM_W){1'b0}}, imm_field}) : '0;

  always_comb begin
    if (imm_valid)
      a_field_kept_r2: assert ((operand[IMM_W-1:0] & imm_field) == imm_field);
    else
      a_quiet_r9: assert (operand == '0);
  end
endmodule

// File: rtl/imx_prefix_unit.sv
module imx_prefix_unit
  import imx_pkg::*;
#(
  parameter int TASK_N = 4,
  localparam int TID_W = (TASK_N > 1) ? $clog2(TASK_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] task_id,
  input  logic             pfx_valid,
  input  logic             pfx_high,
  input  logic [PFX_W-1:0] pfx_payload,
  input  logic             imm_valid,
  input  logic [IMM_W-1:0] imm_field,
  output logic [WORD_W-1:0] operand
);
  word_t held [TASK_N];
  logic [TASK_N-1:0] load_v, use_v;

  for (genvar g = 0; g < TASK_N; g++) begin : g_task
    assign load_v[g] = pfx_valid && (task_id == TID_W'(g));
    assign use_v[g]  = imm_valid && (task_id == TID_W'(g));

    imx_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load_v[g]),
      .load_high    (pfx_high),
      .load_payload (pfx_payload),
      .consume      (use_v[g]),
      .held         (held[g])
    );

    p_other_task_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (task_id != TID_W'(g)) |=> $stable(held[g]));
  end

  imx_merge #(.TASK_N(TASK_N)) u_merge (
    .held      (held),
    .task_id   (task_id),
    .imm_valid (imm_valid),
    .imm_field (imm_field),
    .operand   (operand)
  );

  p_one_hot_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_v) && $onehot0(use_v));
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (held[0] == '0));
endmodule

// File: tb/tb_imx_prefix_unit.sv
module tb_imx_prefix_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  task_id = 0;
  logic        pfx_valid = 0, pfx_high = 0, imm_valid = 0;
  logic [22:0] pfx_payload = 0;
  logic [8:0]  imm_field = 0;
  logic [31:0] operand;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  imx_prefix_unit dut (.*);

  // task, pfx_valid, pfx_high, payload, imm_valid, field, expected operand
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b1, 23'h012345, 1'b0, 9'h000, 32'h0000_0000}, // R2 load
    {2'd0, 1'b0, 1'b0, 23'h0,      1'b1, 9'h0AB, 32'h0246_8AAB}, // R2
    {2'd0, 1'b0, 1'b0, 23'h0,      1'b1, 9'h1FF, 32'h0000_01FF}, // R4
    {2'd1, 1'b1, 1'b0, 23'h7FFFFF, 1'b0, 9'h000, 32'h0000_0000}, // R3 load
    {2'd2, 1'b1, 1'b1, 23'h400001, 1'b0, 9'h000, 32'h0000_0000}, // R5
    {2'd1, 1'b0, 1'b0, 23'h0,      1'b1, 9'h000, 32'h007F_FFFF}, // R3 R5
    {2'd2, 1'b0, 1'b0, 23'h0,      1'b1, 9'h155, 32'h8000_0355}, // R2 R5
    {2'd3, 1'b1, 1'b0, 23'h000100, 1'b0, 9'h000, 32'h0000_0000}, // R7 first
    {2'd3, 1'b0, 1'b0, 23'h0,      1'b0, 9'h1C3, 32'h0000_0000}, // R6 R9
    {2'd3, 1'b1, 1'b1, 23'h000003, 1'b0, 9'h000, 32'h0000_0000}, // R7 overwrite
    {2'd3, 1'b0, 1'b0, 23'h0,      1'b1, 9'h001, 32'h0000_0601}, // R7
    {2'd0, 1'b1, 1'b0, 23'h0000F0, 1'b0, 9'h000, 32'h0000_0000}, // R3 load
    {2'd0, 1'b0, 1'b0, 23'h0,      1'b1, 9'h0F1, 32'h0000_00F1}, // R3 OR not add
    {2'd0, 1'b0, 1'b0, 23'h0,      1'b1, 9'h0F1, 32'h0000_00F1}  // R4
  };

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (operand !== exp) begin
      n_bad++;
      $display("FAIL %s: operand=%h expected=%h", req, operand, exp);
    end
  endtask

  task automatic drive(input logic [1:0] t, input logic pv, input logic ph,
                       input logic [22:0] pp, input logic iv, input logic [8:0] f);
    task_id = t; pfx_valid = pv; pfx_high = ph; pfx_payload = pp;
    imm_valid = iv; imm_field = f;
  endtask

  initial begin
    #100000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every task reads zero-extended field after reset
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); drive(2'(t), 0, 0, 0, 1, 9'h1A5); #1;
      check("R1", 32'h0000_01A5);
    end
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][68:67], VEC[i][66], VEC[i][65], VEC[i][64:42], VEC[i][41], VEC[i][40:32]);
      #1;
      check(VEC[i][41] ? "R2/R3/R4/R5/R7 table" : "R9 table", VEC[i][31:0]);
    end
    // R8: same-cycle prefix and immediate on task 1
    @(negedge clk); drive(2'd1, 1, 0, 23'h20, 0, 0);
    @(negedge clk); drive(2'd1, 1, 1, 23'h1, 1, 9'h00A); #1;
    check("R8 old value", 32'h0000_002A);
    @(negedge clk); drive(2'd1, 0, 0, 0, 1, 9'h000); #1;
    check("R8 new kept", 32'h0000_0200);
    // R1: reset with a value pending on task 2
    @(negedge clk); drive(2'd2, 1, 1, 23'h7ABCDE, 0, 0);
    @(negedge clk); drive(2'd0, 0, 0, 0, 0, 0); rst_n = 0;
    @(negedge clk); rst_n = 1;
    drive(2'd2, 0, 0, 0, 1, 9'h077); #1;
    check("R1 pending cleared", 32'h0000_0077);
    @(negedge clk); drive(2'd0, 0, 0, 0, 0, 0); #1;
    check("R9 idle", 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule